// File: doc/BRIEF.md
# Polarity-Selectable Phase/Frequency Detector with Lock Indication

This block compares two edge streams inside a synthesizer loop: a reference stream and a divided oscillator stream. Both are sampled on a fast system clock. Each low-to-high transition on either input sets an internal "seen" flag. After both flags are set, they stay set together for a fixed minimum number of system-clock cycles and are then released. Because of this, even a perfectly aligned loop produces a short coincident pulse on every comparison, and the detector has no dead zone.

The two flags drive two active-low pulse outputs. A polarity input selects which flag appears on which output, so the loop can match either sign of oscillator tuning slope. When the detector is disabled or the block is in standby, both outputs sit at their high rest level and any pending flags are dropped. The lock indication is the AND of the two active-low outputs, gated by its own enable. After reset it therefore stays low until software enables it. A single-ended pump interface is modelled as a drive-enable bit and a direction bit.

Top module: `pfd_lockdet`

## Requirements
- R1: With polarity low, a rising edge on the oscillator input that arrives before the reference edge drives `vco_pulse_n_o` low from the clock edge that samples it. `ref_pulse_n_o` stays high until the reference edge is sampled.
- R2: With polarity low, a rising edge on the reference input that arrives before the oscillator edge drives `ref_pulse_n_o` low. `vco_pulse_n_o` stays high until the oscillator edge is sampled.
- R3: With polarity high, the two outputs are swapped: the reference flag drives `vco_pulse_n_o` and the oscillator flag drives `ref_pulse_n_o`.
- R4: Once both flags are set, both outputs stay low together for exactly MIN_PULSE system-clock cycles and then return high. This holds even when both edges are sampled in the same cycle.
- R5: While `det_en_i` is low or `standby_i` is high, both pulse outputs are high and both flags are cleared. Edges seen in that time have no effect afterwards.
- R6: When `lock_en_i` is high, `lock_o` equals `ref_pulse_n_o AND vco_pulse_n_o`.
- R7: While `lock_en_i` is low, `lock_o` is low. This includes the time from reset onward.
- R8: `so_drive_o` is 1 exactly when one pulse output is low and the other is high. `so_src_o` is 1 exactly when `so_drive_o` is 1 and the low output is `ref_pulse_n_o`; otherwise it is 0.
- R9: During and right after reset, both pulse outputs are high and `lock_o`, `so_drive_o` and `so_src_o` are 0.
- R10: Only a low-to-high transition of an input sets its flag. An input held high for many cycles does not set the flag again after release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ref_in_i | input | 1 | Reference edge stream |
| vco_in_i | input | 1 | Divided oscillator edge stream |
| polarity_i | input | 1 | 1 swaps the two pulse outputs |
| det_en_i | input | 1 | Detector enable |
| lock_en_i | input | 1 | Lock indication enable |
| standby_i | input | 1 | Standby, forces rest state |
| ref_pulse_n_o | output | 1 | Active-low pulse output, reference side |
| vco_pulse_n_o | output | 1 | Active-low pulse output, oscillator side |
| lock_o | output | 1 | Lock indication (AND of pulse outputs) |
| so_drive_o | output | 1 | Single-ended pump driven (0 = high impedance) |
| so_src_o | output | 1 | Single-ended pump sources current when 1 |

## Verification
Both flags sit one register away from the outputs. A flag that is wrongly set or wrongly held therefore shows up as a misplaced or stretched low pulse on the very next cycle the bench samples. A release counter that is off by one changes the coincident-pulse width, and this appears within MIN_PULSE + 1 cycles of the second edge. The cycle model in the bench compares all five outputs on every clock, across fixed phase orderings, both polarities, standby and enable changes, and a long random run.

// File: rtl/pfd_pkg.sv
package pfd_pkg;

  // Map the two flags onto the two active-low outputs {ref_n, vco_n}.
  function automatic logic [1:0] route_pulses(input logic ref_hit, input logic vco_hit,
                                              input logic pol, input logic active);
    logic a_side;
    logic b_side;
    a_side = pol ? vco_hit : ref_hit;
    b_side = pol ? ref_hit : vco_hit;
    if (!active) return 2'b11;
    return {~a_side, ~b_side};
  endfunction

  // Pump drive: {drive, source}.
  function automatic logic [1:0] pump_ctl(input logic ref_n, input logic vco_n);
    logic drv;
    drv = ref_n ^ vco_n;
    return {drv, drv & ~ref_n};
  endfunction

endpackage

// File: rtl/pfd_edge_det.sv
module pfd_edge_det #(
  parameter int CH = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CH-1:0] sig_i,
  output logic [CH-1:0] rise_o
);

  for (genvar i = 0; i < CH; i++) begin : g_ch
    logic prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= sig_i[i];
    end

    assign rise_o[i] = sig_i[i] & ~prev_q;

    // R10: a rise cannot be reported in two consecutive cycles
    assert_single_rise_R10: assert property (@(posedge clk) disable iff (!rst_n)
      rise_o[i] |=> !rise_o[i]);
  end

endmodule

// File: rtl/pfd_flops.sv
module pfd_flops #(
  parameter int MIN_PULSE = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active_i,
  input  logic ref_rise_i,
  input  logic vco_rise_i,
  output logic ref_hit_o,
  output logic vco_hit_o
);

  localparam int CNT_W = (MIN_PULSE > 1) ? $clog2(MIN_PULSE) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(MIN_PULSE - 1);

  logic             ref_hit_q;
  logic             vco_hit_q;
  logic [CNT_W-1:0] cnt_q;
  logic             both_w;
  logic             release_w;

  assign both_w    = ref_hit_q & vco_hit_q;
  assign release_w = both_w & (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_hit_q <= 1'b0;
      vco_hit_q <= 1'b0;
      cnt_q     <= '0;
    end else if (!active_i) begin
      ref_hit_q <= 1'b0;
      vco_hit_q <= 1'b0;
      cnt_q     <= '0;
    end else begin
      ref_hit_q <= ref_rise_i | (ref_hit_q & ~release_w);
      vco_hit_q <= vco_rise_i | (vco_hit_q & ~release_w);
      cnt_q     <= (both_w & ~release_w) ? cnt_q + 1'b1 : '0;
    end
  end

  assign ref_hit_o = ref_hit_q;
  assign vco_hit_o = vco_hit_q;

  assert_cnt_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);
  assert_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (release_w && !ref_rise_i && !vco_rise_i) |=> (!ref_hit_q && !vco_hit_q));
  assert_idle_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !active_i |=> (!ref_hit_q && !vco_hit_q));

endmodule

// File: rtl/pfd_lockdet.sv
module pfd_lockdet #(
  parameter int MIN_PULSE = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_in_i,
  input  logic vco_in_i,
  input  logic polarity_i,
  input  logic det_en_i,
  input  logic lock_en_i,
  input  logic standby_i,
  output logic ref_pulse_n_o,
  output logic vco_pulse_n_o,
  output logic lock_o,
  output logic so_drive_o,
  output logic so_src_o
);
  import pfd_pkg::*;

  logic [1:0] rise_w;
  logic       active_w;
  logic       ref_hit_w;
  logic       vco_hit_w;
  logic [1:0] pulses_w;
  logic [1:0] pump_w;

  assign active_w = det_en_i & ~standby_i;

  pfd_edge_det #(.CH(2)) u_edge (
    .clk   (clk),
    .rst_n (rst_n),
    .sig_i ({vco_in_i, ref_in_i}),
    .rise_o(rise_w)
  );

  pfd_flops #(.MIN_PULSE(MIN_PULSE)) u_flops (
    .clk       (clk),
    .rst_n     (rst_n),
    .active_i  (active_w),
    .ref_rise_i(rise_w[0]),
    .vco_rise_i(rise_w[1]),
    .ref_hit_o (ref_hit_w),
    .vco_hit_o (vco_hit_w)
  );

  assign pulses_w      = route_pulses(ref_hit_w, vco_hit_w, polarity_i, active_w);
  assign ref_pulse_n_o = pulses_w[1];
  assign vco_pulse_n_o = pulses_w[0];
  assign lock_o        = lock_en_i & ref_pulse_n_o & vco_pulse_n_o;
  assign pump_w        = pump_ctl(ref_pulse_n_o, vco_pulse_n_o);
  assign so_drive_o    = pump_w[1];
  assign so_src_o      = pump_w[0];

  assert_rest_level_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (standby_i || !det_en_i) |-> (ref_pulse_n_o && vco_pulse_n_o && !so_drive_o));
  assert_lock_and_R6: assert property (@(posedge clk) disable iff (!rst_n)
    lock_o |-> (ref_pulse_n_o && vco_pulse_n_o));
  assert_lock_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !lock_en_i |-> !lock_o);
  assert_pump_tri_R8: assert property (@(posedge clk) disable iff (!rst_n)
    so_drive_o |-> (ref_pulse_n_o != vco_pulse_n_o));
  assert_pump_dir_R8: assert property (@(posedge clk) disable iff (!rst_n)
    so_src_o |-> (so_drive_o && !ref_pulse_n_o));

endmodule

// File: tb/pfd_lockdet_tb.sv
`timescale 1ns/1ps
module pfd_lockdet_tb;
  localparam int MINP = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ref_in = 1'b0, vco_in = 1'b0, pol = 1'b0, det_en = 1'b0, lock_en = 1'b0, stby = 1'b0;
  logic ref_n, vco_n, lock, drv, src;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 0;
  string cur_req = "R9";

  // behavioural model state
  bit m_prev_ref = 0, m_prev_vco = 0;
  bit m_ref_seen = 0, m_vco_seen = 0;
  int m_hold = 0;

  always #2.5 clk = ~clk;

  pfd_lockdet #(.MIN_PULSE(MINP)) u_dut (
    .clk(clk), .rst_n(rst_n), .ref_in_i(ref_in), .vco_in_i(vco_in),
    .polarity_i(pol), .det_en_i(det_en), .lock_en_i(lock_en), .standby_i(stby),
    .ref_pulse_n_o(ref_n), .vco_pulse_n_o(vco_n), .lock_o(lock),
    .so_drive_o(drv), .so_src_o(src)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_prev_ref = 0; m_prev_vco = 0; m_ref_seen = 0; m_vco_seen = 0; m_hold = 0;
    end else begin
      bit new_ref, new_vco, pair;
      new_ref = ref_in && !m_prev_ref;
      new_vco = vco_in && !m_prev_vco;
      m_prev_ref = ref_in;
      m_prev_vco = vco_in;
      if (!det_en || stby) begin
        m_ref_seen = 0; m_vco_seen = 0; m_hold = 0;
      end else begin
        pair = m_ref_seen && m_vco_seen;
        if (pair && m_hold + 1 >= MINP) begin
          m_ref_seen = new_ref; m_vco_seen = new_vco; m_hold = 0;
        end else begin
          m_hold = pair ? m_hold + 1 : 0;
          m_ref_seen = m_ref_seen || new_ref;
          m_vco_seen = m_vco_seen || new_vco;
        end
      end
    end
  end

  task automatic chk(input string what, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s %s: got %0b expected %0b at %0t", cur_req, what, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    bit e_ref_n, e_vco_n, on;
    on = det_en && !stby;
    if (!on) begin e_ref_n = 1; e_vco_n = 1; end
    else if (!pol) begin e_ref_n = !m_ref_seen; e_vco_n = !m_vco_seen; end
    else begin e_ref_n = !m_vco_seen; e_vco_n = !m_ref_seen; end
    chk("ref_pulse_n", ref_n, e_ref_n);
    chk("vco_pulse_n", vco_n, e_vco_n);
    chk("lock", lock, lock_en && e_ref_n && e_vco_n);
    chk("so_drive", drv, e_ref_n != e_vco_n);
    chk("so_src", src, (e_ref_n != e_vco_n) && !e_ref_n);
  endtask

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      compare_all();
    end
  endtask

  // first input rises, the other follows after gap cycles, both fall later
  task automatic edge_pair(input bit vco_first, input int gap);
    if (vco_first) vco_in = 1; else ref_in = 1;
    tick(gap);
    ref_in = 1; vco_in = 1;
    tick(3);
    ref_in = 0; vco_in = 0;
    tick(4);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    cur_req = "R9";
    @(negedge clk); @(negedge clk);
    chk("reset ref_pulse_n R9", ref_n, 1'b1);
    chk("reset vco_pulse_n R9", vco_n, 1'b1);
    chk("reset lock R9", lock, 1'b0);
    chk("reset so_drive R9", drv, 1'b0);
    rst_n = 1;
    det_en = 1;
    tick(2);

    cur_req = "R7"; // lock stays low with enable low while edges run
    edge_pair(1, 3);

    lock_en = 1;
    cur_req = "R1"; edge_pair(1, 4);
    cur_req = "R2"; edge_pair(0, 4);
    cur_req = "R4"; edge_pair(0, 0); // simultaneous edges: coincident pulse only
    edge_pair(1, 1);
    cur_req = "R3"; pol = 1; tick(1);
    edge_pair(1, 3); edge_pair(0, 5);
    pol = 0;

    cur_req = "R10"; ref_in = 1; tick(20); vco_in = 1; tick(20);
    ref_in = 0; vco_in = 0; tick(4);

    cur_req = "R5"; vco_in = 1; tick(2); stby = 1; tick(3);
    ref_in = 1; tick(2); stby = 0; tick(4);
    ref_in = 0; vco_in = 0; tick(2);
    det_en = 0; ref_in = 1; tick(3); det_en = 1; tick(4);
    ref_in = 0; tick(2);

    cur_req = "R6 R8"; // random run over all controls
    for (int i = 0; i < 3000; i++) begin
      ref_in = $urandom_range(0, 1);
      vco_in = $urandom_range(0, 1);
      if ($urandom_range(0, 40) == 0) pol = ~pol;
      if ($urandom_range(0, 60) == 0) stby = ~stby;
      if ($urandom_range(0, 80) == 0) det_en = ~det_en;
      if ($urandom_range(0, 50) == 0) lock_en = ~lock_en;
      tick(1);
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule